// File: doc/BRIEF.md
# Parallel card bus cycle sequencer

This block runs single read and write cycles on a simple parallel I/O card bus, in place of a processor toggling bus lines one register write at a time. A request port with a valid/ready handshake takes a direction bit, a 4-bit card/register address and a write byte. The block then plays out a fixed sequence of bus phases, and each phase lasts a number of clock cycles computed from nanosecond parameters. Read data is returned with a one-cycle done pulse.

On the bus side there are four address lines, a card select, a read strobe, a write strobe and eight open-collector data lines. Each data line has a pull-down enable output and a line level input. A polarity parameter selects between an inverted (active-low) bus and a true (active-high) bus. A per-bit input mask keeps chosen data lines released during writes, so those lines can serve as inputs while the others are outputs. A read always returns all eight lines.

Top module: `card_bus_seq`

## Requirements
- R1: `reqReady` is high whenever no cycle is in progress. A request is accepted at a rising edge where `reqValid` and `reqReady` are both high. `reqReady` is low from that edge until the cycle after the final release phase. Requests presented while `reqReady` is low are ignored and do not change the cycle in progress.
- R2: A write cycle runs in this order, counting from the acceptance edge. Address and select are presented for S cycles. The data drivers are then enabled for S more cycles. The write strobe is active for W cycles. The strobe is then off for H hold cycles, with address, select and data unchanged. Address and select are then removed for one cycle while the data stays driven. One final release cycle follows with everything idle.
- R3: A read cycle presents address and select for S cycles, then holds the read strobe for R cycles. The data lines are sampled at the last strobe cycle. Address and select remain for H cycles after the strobe ends, then one release cycle follows. The data drivers stay off for the whole read.
- R4: `rspDone` is high for exactly one cycle, the release cycle of every read or write. `rspRdata` gives the logical byte sampled by the most recent read, and a write does not change it.
- R5: Each phase length is ceil(ns × CLK_KHZ / 10^6) cycles, and at least 1. With the defaults at 250 MHz, this gives S=3 (10 ns), W=500 (2000 ns), R=500 (2000 ns) and H=8 (30 ns).
- R6: With BUS_ACTIVE_LOW=1, the pins carry the inverse of the logical address, select and strobes, so the idle pin values are all ones. A data driver pulls its line low for a logical 1, and a read returns the inverted line level. With BUS_ACTIVE_LOW=0, every pin is true. A driver pulls its line for a logical 0, and a read returns the line level as it is.
- R7: A data bit whose INPUT_MASK bit is 1 never has its driver enabled. Reads return all eight lines regardless of the mask.
- R8: The read and write strobes are never active together. Neither strobe is active without the select. The address pins do not change while the select stays active.
- R9: While `rstN` is low, the block is idle: `reqReady` is 1, `rspDone` is 0, `rspRdata` is 0, all drivers are off, and address, select and strobes are at their inactive pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqAddr | input | ADDR_W | Card/register address |
| reqWdata | input | DATA_W | Byte to write |
| rspDone | output | 1 | One-cycle pulse at the end of a cycle |
| rspRdata | output | DATA_W | Logical byte from the last read |
| busAddr | output | ADDR_W | Address pins |
| busSel | output | 1 | Card select pin |
| busRdStb | output | 1 | Read strobe pin |
| busWrStb | output | 1 | Write strobe pin |
| busDataOe | output | DATA_W | Per-line pull-down enable |
| busDataIn | input | DATA_W | Data line levels |

## Verification
Every bus pin follows from the sequencer state with no added register stage. After the acceptance edge, a write therefore shows its address on the first cycle, its drivers on cycle S, its strobe on cycle 2S and its done pulse on cycle 2S+W+H+1. A read shows its strobe on cycle S and its done pulse on cycle S+R+H. `reqReady` returns one cycle after done. The bench model keeps its own cycle counter for each accepted request and derives every pin level from these offsets. It compares all outputs at each falling edge, after the rising edge that moved them and before the next inputs take effect. `rspRdata` is compared only when done is high or the block is idle, because the new byte appears H cycles before done.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DRIVE,
    PH_STRB,
    PH_HOLD,
    PH_UNSEL,
    PH_REL
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic present;
    logic drive;
    logic rdStb;
    logic wrStb;
    logic sample;
    logic done;
  } ctl_t;

  // round a time up to whole clock cycles, minimum one
  function automatic int nsToCycles(longint ns, longint khz);
    longint c;
    c = (ns * khz + 64'd999999) / 64'd1000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/cbs_ctrl.sv
module cbs_ctrl
  import cbs_pkg::*;
#(
  parameter int SETUP_CYC  = 3,
  parameter int STROBE_CYC = 500,
  parameter int SETTLE_CYC = 500,
  parameter int HOLD_CYC   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  output logic reqReady,
  output ctl_t ctl
);

  localparam int MAX_AB = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_CD = (STROBE_CYC > SETTLE_CYC) ? STROBE_CYC : SETTLE_CYC;
  localparam int MAX_D  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_D + 1);

  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             isWrite;
  logic             expire;
  logic             accept;

  assign expire = (cnt == '0);
  assign accept = (phase == PH_IDLE) && reqValid;

  always_comb begin
    phaseNext = phase;
    cntNext   = expire ? cnt : cnt - 1'b1;
    case (phase)
      PH_IDLE: if (reqValid) begin
        phaseNext = PH_ADDR;
        cntNext   = LD_SETUP;
      end
      PH_ADDR: if (expire) begin
        phaseNext = isWrite ? PH_DRIVE : PH_STRB;
        cntNext   = isWrite ? LD_SETUP : LD_SETTLE;
      end
      PH_DRIVE: if (expire) begin
        phaseNext = PH_STRB;
        cntNext   = LD_STROBE;
      end
      PH_STRB: if (expire) begin
        phaseNext = PH_HOLD;
        cntNext   = LD_HOLD;
      end
      PH_HOLD: if (expire) begin
        phaseNext = isWrite ? PH_UNSEL : PH_REL;
        cntNext   = '0;
      end
      PH_UNSEL: phaseNext = PH_REL;
      PH_REL:   phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
      if (accept) isWrite <= reqWrite;
    end
  end

  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    ctl.load    = accept;
    ctl.present = (phase == PH_ADDR) || (phase == PH_DRIVE) ||
                  (phase == PH_STRB) || (phase == PH_HOLD);
    ctl.drive   = isWrite && ((phase == PH_DRIVE) || (phase == PH_STRB) ||
                              (phase == PH_HOLD) || (phase == PH_UNSEL));
    ctl.rdStb   = !isWrite && (phase == PH_STRB);
    ctl.wrStb   = isWrite && (phase == PH_STRB);
    ctl.sample  = !isWrite && (phase == PH_STRB) && expire;
    ctl.done    = (phase == PH_REL);
  end

endmodule

// File: rtl/cbs_datapath.sv
module cbs_datapath
  import cbs_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter bit                ACT_LOW    = 1'b1,
  parameter logic [DATA_W-1:0] INPUT_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busSel,
  output logic              busRdStb,
  output logic              busWrStb,
  output logic [DATA_W-1:0] busDataOe,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ, addrLogic;
  logic [DATA_W-1:0] wdataQ, rdQ;
  logic [DATA_W-1:0] pullPat;
  logic [DATA_W-1:0] rdSense;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.sample) rdQ <= rdSense;
    end
  end

  assign addrLogic = ctl.present ? addrQ : '0;

  generate
    if (ACT_LOW) begin : g_inverted
      assign busAddr  = ~addrLogic;
      assign busSel   = ~ctl.present;
      assign busRdStb = ~ctl.rdStb;
      assign busWrStb = ~ctl.wrStb;
      assign pullPat  = wdataQ;
      assign rdSense  = ~busDataIn;
    end else begin : g_true
      assign busAddr  = addrLogic;
      assign busSel   = ctl.present;
      assign busRdStb = ctl.rdStb;
      assign busWrStb = ctl.wrStb;
      assign pullPat  = ~wdataQ;
      assign rdSense  = busDataIn;
    end
  endgenerate

  assign busDataOe = ctl.drive ? (pullPat & ~INPUT_MASK) : '0;
  assign rspDone   = ctl.done;
  assign rspRdata  = rdQ;

endmodule

// File: rtl/card_bus_seq.sv
module card_bus_seq
  import cbs_pkg::*;
#(
  parameter int                ADDR_W         = 4,
  parameter int                DATA_W         = 8,
  parameter int                CLK_KHZ        = 250000,
  parameter int                SETUP_NS       = 10,
  parameter int                STROBE_NS      = 2000,
  parameter int                SETTLE_NS      = 2000,
  parameter int                HOLD_NS        = 30,
  parameter bit                BUS_ACTIVE_LOW = 1'b1,
  parameter logic [DATA_W-1:0] INPUT_MASK     = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busSel,
  output logic              busRdStb,
  output logic              busWrStb,
  output logic [DATA_W-1:0] busDataOe,
  input  logic [DATA_W-1:0] busDataIn
);

  localparam int SETUP_CYC  = nsToCycles(SETUP_NS, CLK_KHZ);
  localparam int STROBE_CYC = nsToCycles(STROBE_NS, CLK_KHZ);
  localparam int SETTLE_CYC = nsToCycles(SETTLE_NS, CLK_KHZ);
  localparam int HOLD_CYC   = nsToCycles(HOLD_NS, CLK_KHZ);

  ctl_t ctl;

  cbs_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  cbs_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ACT_LOW   (BUS_ACTIVE_LOW),
    .INPUT_MASK(INPUT_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busDataIn(busDataIn),
    .busAddr  (busAddr),
    .busSel   (busSel),
    .busRdStb (busRdStb),
    .busWrStb (busWrStb),
    .busDataOe(busDataOe),
    .rspDone  (rspDone),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter int                CLK_KHZ    = 250000,
  parameter int                STROBE_NS  = 2000,
  parameter int                SETTLE_NS  = 2000,
  parameter bit                ACT_LOW    = 1'b1,
  parameter logic [DATA_W-1:0] INPUT_MASK = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busSel,
  input logic              busRdStb,
  input logic              busWrStb,
  input logic [DATA_W-1:0] busDataOe
);

  localparam int STRB_CYC = cbs_pkg::nsToCycles(STROBE_NS, CLK_KHZ);
  localparam int SETL_CYC = cbs_pkg::nsToCycles(SETTLE_NS, CLK_KHZ);

  logic selAct, rdAct, wrAct;
  int   wrRun, rdRun;

  assign selAct = ACT_LOW ? ~busSel : busSel;
  assign rdAct  = ACT_LOW ? ~busRdStb : busRdStb;
  assign wrAct  = ACT_LOW ? ~busWrStb : busWrStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrRun <= 0;
      rdRun <= 0;
    end else begin
      wrRun <= wrAct ? wrRun + 1 : 0;
      rdRun <= rdAct ? rdRun + 1 : 0;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdAct && wrAct)); // R8
  AST_STROBE_UNDER_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct || wrAct) |-> selAct); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (selAct && $past(selAct)) |-> $stable(busAddr)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (selAct || (busDataOe != '0)) |-> !reqReady); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R4
  AST_MASK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (busDataOe & INPUT_MASK) == '0); // R7
  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrAct) |-> (wrRun >= STRB_CYC)); // R5
  AST_RD_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdAct) |-> (rdRun >= SETL_CYC)); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrAct) |-> ($stable(busDataOe) && selAct)); // R2

endmodule

bind card_bus_seq cbs_checker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CLK_KHZ   (CLK_KHZ),
  .STROBE_NS (STROBE_NS),
  .SETTLE_NS (SETTLE_NS),
  .ACT_LOW   (BUS_ACTIVE_LOW),
  .INPUT_MASK(INPUT_MASK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspDone  (rspDone),
  .busAddr  (busAddr),
  .busSel   (busSel),
  .busRdStb (busRdStb),
  .busWrStb (busWrStb),
  .busDataOe(busDataOe)
);

// File: tb/card_bus_seq_test.sv
module card_bus_seq_test;

  // phase lengths from R5 at 250 MHz: ceil(ns / 4)
  localparam int S = (10 + 3) / 4;
  localparam int W = (2000 + 3) / 4;
  localparam int R = (2000 + 3) / 4;
  localparam int H = (30 + 3) / 4;
  localparam logic [7:0] MASK_HI = 8'hF0;
  localparam int NREQ = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN;
  logic       reqValid, reqWrite;
  logic [3:0] reqAddr;
  logic [7:0] reqWdata;

  logic       rdyL, doneL, selL, rdL, wrL;
  logic [7:0] rdataL, oeL, inL;
  logic [3:0] addrL;
  logic       rdyH, doneH, selH, rdH, wrH;
  logic [7:0] rdataH, oeH, inH;
  logic [3:0] addrH;

  card_bus_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(rdyL),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(doneL), .rspRdata(rdataL), .busAddr(addrL), .busSel(selL),
    .busRdStb(rdL), .busWrStb(wrL), .busDataOe(oeL), .busDataIn(inL));

  card_bus_seq #(.BUS_ACTIVE_LOW(1'b0), .INPUT_MASK(MASK_HI)) uutHigh (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(rdyH),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(doneH), .rspRdata(rdataH), .busAddr(addrH), .busSel(selH),
    .busRdStb(rdH), .busWrStb(wrH), .busDataOe(oeH), .busDataIn(inH));

  function automatic logic [7:0] cardVal(input logic [3:0] a);
    return 8'({4'h0, a} * 8'h3B) ^ 8'hA5;
  endfunction

  // card model: drives its byte only while its read strobe is active; wired-AND with pull-downs
  logic [7:0] lvlL, lvlH;
  always_comb begin
    lvlL = (!rdL) ? ~cardVal(~addrL) : 8'hFF;
    lvlH = rdH ? cardVal(addrH) : 8'hFF;
  end
  assign inL = lvlL & ~oeL;
  assign inH = lvlH & ~oeH;

  int checks = 0;
  int fails = 0;

  // reference model state
  bit         busy;
  int         t;
  logic       mW;
  logic [3:0] mA;
  logic [7:0] mD;
  logic [7:0] expRd;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0d", req, what, act, exp, t);
    end
  endtask

  task automatic checkSide(input bit al, input logic [7:0] mask, input string nm,
                           input logic rdy, input logic done, input logic [3:0] addr,
                           input logic sel, input logic rd, input logic wr,
                           input logic [7:0] oe, input logic [7:0] rdata, input bit inRst);
    bit pres, drv, rdA, wrA, dn;
    logic [7:0] pull;
    string rq;
    pres = 0; drv = 0; rdA = 0; wrA = 0; dn = 0;
    if (busy && mW) begin
      pres = t < 2*S + W + H;
      drv  = (t >= S) && (t < 2*S + W + H + 1);
      wrA  = (t >= 2*S) && (t < 2*S + W);
      dn   = t == 2*S + W + H + 1;
    end else if (busy) begin
      pres = t < S + R + H;
      rdA  = (t >= S) && (t < S + R);
      dn   = t == S + R + H;
    end
    pull = al ? mD : ~mD;
    rq = inRst ? "R9" : "";
    check(inRst ? rq : "R1", {nm, " ready"}, 32'(rdy), 32'(!busy));
    check(inRst ? rq : "R4", {nm, " done"}, 32'(done), 32'(dn));
    check(inRst ? rq : "R6", {nm, " select"}, 32'(sel), 32'(al ? !pres : pres));
    check(inRst ? rq : (mW ? "R2" : "R3"), {nm, " address"}, 32'(addr),
          32'((pres ? mA : 4'h0) ^ {4{al}}));
    check(inRst ? rq : "R5", {nm, " write strobe"}, 32'(wr), 32'(al ? !wrA : wrA));
    check(inRst ? rq : (al ? "R3" : "R8"), {nm, " read strobe"}, 32'(rd),
          32'(al ? !rdA : rdA));
    check(inRst ? rq : (mask != 0 ? "R7" : "R2"), {nm, " drivers"}, 32'(oe),
          32'(drv ? (pull & ~mask) : 8'h00));
    if (!busy || dn)
      check(inRst ? rq : (mask != 0 ? "R7" : "R4"), {nm, " read data"}, 32'(rdata),
            32'(expRd));
  endtask

  logic       qW [NREQ];
  logic [3:0] qA [NREQ];
  logic [7:0] qD [NREQ];

  initial begin
    int idx, gap, total, cyc;
    bit running;
    // directed requests, then pseudo-random ones
    qW[0] = 1; qA[0] = 4'h0; qD[0] = 8'h00;
    qW[1] = 1; qA[1] = 4'hF; qD[1] = 8'hFF;
    qW[2] = 0; qA[2] = 4'h3; qD[2] = 8'h11;
    qW[3] = 0; qA[3] = 4'hF; qD[3] = 8'h22;
    qW[4] = 1; qA[4] = 4'h5; qD[4] = 8'hA5;
    qW[5] = 0; qA[5] = 4'h0; qD[5] = 8'h33;
    qW[6] = 1; qA[6] = 4'hA; qD[6] = 8'h3C;
    for (int i = 7; i < NREQ; i++) begin
      qW[i] = 1'($urandom);
      qA[i] = 4'($urandom);
      qD[i] = 8'($urandom);
    end

    busy = 0; t = 0; mW = 0; mA = 0; mD = 0; expRd = 8'h00;
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = 0; reqWdata = 0;
    // R9: reset state
    repeat (4) begin
      @(negedge clk);
      checkSide(1'b1, 8'h00, "low", rdyL, doneL, addrL, selL, rdL, wrL, oeL, rdataL, 1'b1);
      checkSide(1'b0, MASK_HI, "high", rdyH, doneH, addrH, selH, rdH, wrH, oeH, rdataH, 1'b1);
    end
    rstN = 1;

    idx = 0; gap = 1; cyc = 0; total = 0; running = 1;
    while (running) begin
      @(negedge clk);
      cyc++;
      if (busy && !mW && t == S + R + H) expRd = cardVal(mA);
      checkSide(1'b1, 8'h00, "low", rdyL, doneL, addrL, selL, rdL, wrL, oeL, rdataL, 1'b0);
      checkSide(1'b0, MASK_HI, "high", rdyH, doneH, addrH, selH, rdH, wrH, oeH, rdataH, 1'b0);
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL R1 watchdog actual=%0d expected<=150000", cyc);
        running = 0;
      end else if (!busy && idx == NREQ && gap == 0) begin
        running = 0;
      end
      // inputs for the next rising edge; R1: junk requests while busy
      if (busy) begin
        reqValid = 1'($urandom);
        reqWrite = 1'($urandom);
        reqAddr  = 4'($urandom);
        reqWdata = 8'($urandom);
      end else if (idx < NREQ && gap == 0) begin
        reqValid = 1; reqWrite = qW[idx]; reqAddr = qA[idx]; reqWdata = qD[idx];
      end else begin
        reqValid = 0;
        if (gap > 0) gap--;
      end
      // advance the model over that edge
      if (busy) begin
        t++;
        if (t == total) busy = 0;
      end else if (reqValid) begin
        busy = 1; t = 0;
        mW = reqWrite; mA = reqAddr; mD = reqWdata;
        total = mW ? 2*S + W + H + 2 : S + R + H + 1;
        idx++;
        gap = idx % 3;
      end
    end
    reqValid = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule